// File: doc/BRIEF.md
# Quad SPI Transfer Engine

This block is the serial side of a half-duplex SPI controller. A single start strobe, qualified by a configuration word, launches one transfer. The word holds a chip-select index, a 3-bit lane mode, a direction bit, a fragment flag and a 16-bit byte count. The engine then shifts that many bytes over one, two or four data lines, in one direction only, and pulses `done` when the last byte has finished. SCLK runs in SPI mode 0. One SCLK period is four core clocks.

Write data comes in on a valid/ready byte stream. The engine takes a byte only at the start of each byte slot. While `tx_valid` is low, SCLK is held low and nothing is lost. Read data leaves on a valid/ready byte stream through a one-byte holding register. Once `rx_valid` is high, `rx_data` stays fixed until `rx_ready` is seen. The engine will not overwrite an unread byte: it waits at the byte boundary with SCLK low. A consumer may pop the holding register in the same cycle the engine refills it.

Setting the fragment flag keeps the chip select asserted after the final byte, so the next transfer continues the same frame. The lines IO2 and IO3 are driven high whenever they are not carrying quad data.

Top module: `qspi_xfer_engine`

## Requirements
- R1: The lane-mode field value 2 selects two lanes and value 3 selects four lanes. Every other value (0, 1, 4, 5, 6, 7) runs as a single lane. A byte therefore takes 8, 4 or 2 SCLK periods.
- R2: Writes shift MSB first. In single mode the bit is on IO0. In dual mode the bit pair is on IO1:IO0 with IO1 carrying the higher bit. In quad mode the nibble is on IO3:IO0 with IO3 carrying the highest bit.
- R3: Reads sample on the rising SCLK edge, MSB first. Single mode samples IO1, dual mode samples IO1:IO0 and quad mode samples IO3:IO0. The assembled bytes leave on the rx stream in order.
- R4: SCLK idles low. Each period is two core cycles low followed by two core cycles high. A transfer of N bytes gives exactly N times the per-byte period count of rising edges.
- R5: `cs_n` is active low. Index 0 selects `cs_n[0]` and index 1 selects `cs_n[1]`. At most one line is low, and the selected line is low on every rising SCLK edge.
- R6: When the fragment flag is 1, the selected chip select stays low after completion. When it is 0, both lines are high once `done` is seen.
- R7: A zero byte count raises `done` on the cycle after the start edge. SCLK does not toggle. The select line and held state are unchanged, except that a clear fragment flag releases a held chip select.
- R8: `done` is high for exactly one cycle after the last byte, and at that point `busy` is low. A start strobe while `busy` is high is ignored.
- R9: During a read, IO0 and IO1 are undriven, and so are IO2 and IO3 in quad mode. During a write, only the lanes of the selected mode are driven among IO0 and IO1, and all four lanes are driven in quad mode.
- R10: When not busy in quad mode, IO2 and IO3 have their enables high and output 1.
- R11: A tx byte is accepted only at a byte boundary. While no byte is offered, SCLK stays low, and every offered byte goes out exactly once, in order.
- R12: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold. No received byte is dropped or duplicated under consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, sampled only when idle |
| cfg_cs | input | 1 | Chip-select index |
| cfg_mode | input | 3 | Lane mode: 2 dual, 3 quad, otherwise single |
| cfg_write | input | 1 | 1 write, 0 read |
| cfg_frag | input | 1 | Keep chip select asserted after the transfer |
| cfg_count | input | 16 | Number of bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_valid | input | 1 | Write byte offered |
| tx_ready | output | 1 | Engine takes the byte this cycle |
| tx_data | input | 8 | Write byte |
| rx_valid | output | 1 | Read byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Read byte |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 2 | Active-low chip selects |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
Two actions can land on the same clock edge. The engine can refill the rx holding register at a byte boundary in the same cycle that the consumer pops it. The tx handshake can complete in the very cycle the engine enters a byte slot after a stall. The sweep provokes both by gating `tx_valid` and `rx_ready` with periodic stall patterns of different lengths (5 and 7 cycles). Across every mode, direction and count, these patterns line a pop up against a refill many times. Results are judged at the ports: every received byte must match, in order, with the pop count equal to the byte count. Every written byte must be reconstructed from lanes captured on rising SCLK. The number of rising SCLK edges must equal the count times the per-byte period count, which shows that a stall never leaked an extra clock.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [1:0] {
    LW_X1 = 2'd0,
    LW_X2 = 2'd1,
    LW_X4 = 2'd2
  } lane_w_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STORE = 2'd3
  } seq_st_e;

  localparam logic [2:0] MODE_DUAL = 3'd2;
  localparam logic [2:0] MODE_QUAD = 3'd3;
  localparam int         LANES     = 4;
endpackage

// File: rtl/qspi_lane_decode.sv
module qspi_lane_decode
  import qspi_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int STEP_W = $clog2(BYTE_W)
) (
  input  logic [2:0]        mode,
  output lane_w_e           lw,
  output logic [STEP_W-1:0] last_step,
  output logic [LANES-1:0]  lane_mask
);
  always_comb begin
    case (mode)
      MODE_DUAL: begin
        lw        = LW_X2;
        last_step = STEP_W'(BYTE_W / 2 - 1);
        lane_mask = 4'b0011;
      end
      MODE_QUAD: begin
        lw        = LW_X4;
        last_step = STEP_W'(BYTE_W / 4 - 1);
        lane_mask = 4'b1111;
      end
      default: begin
        lw        = LW_X1;
        last_step = STEP_W'(BYTE_W - 1);
        lane_mask = 4'b0001;
      end
    endcase
  end
endmodule

// File: rtl/qspi_shift_unit.sv
module qspi_shift_unit
  import qspi_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int STEP_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              write,
  input  lane_w_e           lw,
  input  logic [STEP_W-1:0] last_step,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic [LANES-1:0]  io_in,
  output logic              sclk,
  output logic              byte_end,
  output logic [BYTE_W-1:0] shreg,
  output logic [LANES-1:0]  tx_lanes
);
  logic [1:0]        ph;
  logic [STEP_W-1:0] step;
  logic [BYTE_W-1:0] shift_in;
  logic [BYTE_W-1:0] shift_out;

  assign sclk     = ph[1];
  assign byte_end = run && (ph == 2'd3) && (step == last_step);

  always_comb begin
    case (lw)
      LW_X2: begin
        shift_in  = {shreg[BYTE_W-3:0], io_in[1:0]};
        shift_out = {shreg[BYTE_W-3:0], 2'b00};
        tx_lanes  = {2'b00, shreg[BYTE_W-1 -: 2]};
      end
      LW_X4: begin
        shift_in  = {shreg[BYTE_W-5:0], io_in[3:0]};
        shift_out = {shreg[BYTE_W-5:0], 4'b0000};
        tx_lanes  = shreg[BYTE_W-1 -: 4];
      end
      default: begin
        shift_in  = {shreg[BYTE_W-2:0], io_in[1]};
        shift_out = {shreg[BYTE_W-2:0], 1'b0};
        tx_lanes  = {3'b000, shreg[BYTE_W-1]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      step  <= '0;
      shreg <= '0;
    end else begin
      ph <= run ? ph + 2'd1 : 2'd0;
      if (!run)            step <= '0;
      else if (ph == 2'd3) step <= step + 1'b1;
      if (load)                               shreg <= load_data;
      else if (run && !write && ph == 2'd1)   shreg <= shift_in;
      else if (run && write && ph == 2'd3)    shreg <= shift_out;
    end
  end

  assert_sclk_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk ##1 !sclk);
  assert_sclk_low_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);
endmodule

// File: rtl/qspi_xfer_engine.sv
module qspi_xfer_engine
  import qspi_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  parameter int NUM_CS = 2,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int STEP_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CS_W-1:0]   cfg_cs,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_write,
  input  logic              cfg_frag,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              busy,
  output logic              done,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n,
  output logic [LANES-1:0]  io_out,
  output logic [LANES-1:0]  io_oe,
  input  logic [LANES-1:0]  io_in
);
  seq_st_e           state;
  logic [CNT_W-1:0]  rem;
  logic [CS_W-1:0]   cs_sel;
  logic              cs_act;
  logic              wr_q;
  logic              frag_q;
  logic [2:0]        mode_q;
  logic              done_q;
  logic              rx_valid_q;
  logic [BYTE_W-1:0] rx_data_q;

  lane_w_e           lw;
  logic [STEP_W-1:0] last_step;
  logic [LANES-1:0]  lane_mask;
  logic              byte_end;
  logic [BYTE_W-1:0] shreg;
  logic [LANES-1:0]  tx_lanes;
  logic              quad;
  logic              rx_free;

  qspi_lane_decode #(.BYTE_W(BYTE_W)) u_decode (
    .mode      (mode_q),
    .lw        (lw),
    .last_step (last_step),
    .lane_mask (lane_mask)
  );

  qspi_shift_unit #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state == ST_SHIFT),
    .write     (wr_q),
    .lw        (lw),
    .last_step (last_step),
    .load      (tx_ready && tx_valid),
    .load_data (tx_data),
    .io_in     (io_in),
    .sclk      (sclk),
    .byte_end  (byte_end),
    .shreg     (shreg),
    .tx_lanes  (tx_lanes)
  );

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign tx_ready = (state == ST_LOAD) && wr_q;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign rx_free  = !rx_valid_q || rx_ready;
  assign quad     = (lw == LW_X4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rem        <= '0;
      cs_sel     <= '0;
      cs_act     <= 1'b0;
      wr_q       <= 1'b0;
      frag_q     <= 1'b0;
      mode_q     <= 3'd1;
      done_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (rx_valid_q && rx_ready) rx_valid_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (cfg_count == '0) begin
              done_q <= 1'b1;
              if (!cfg_frag) cs_act <= 1'b0;
            end else begin
              mode_q <= cfg_mode;
              wr_q   <= cfg_write;
              frag_q <= cfg_frag;
              cs_sel <= cfg_cs;
              cs_act <= 1'b1;
              rem    <= cfg_count;
              state  <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (!wr_q || tx_valid) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (byte_end) state <= ST_STORE;
        end
        ST_STORE: begin
          if (wr_q || rx_free) begin
            if (!wr_q) begin
              rx_data_q  <= shreg;
              rx_valid_q <= 1'b1;
            end
            rem <= rem - 1'b1;
            if (rem == CNT_W'(1)) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
              cs_act <= frag_q;
            end else begin
              state <= ST_LOAD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(cs_act && (cs_sel == CS_W'(i)));
  end

  always_comb begin
    io_oe[1:0]  = (busy && wr_q) ? lane_mask[1:0] : 2'b00;
    io_oe[3:2]  = (busy && quad) ? (wr_q ? lane_mask[3:2] : 2'b00) : 2'b11;
    io_out[1:0] = tx_lanes[1:0];
    io_out[3:2] = (busy && quad) ? tx_lanes[3:2] : 2'b11;
  end

  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_rx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  assert_read_undriven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tx_ready && !wr_q |-> io_oe[1:0] == 2'b00);
  assert_tx_at_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> busy && !sclk);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
endmodule

// File: tb/qspi_xfer_engine_tb.sv
module qspi_xfer_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [0:0] cfg_cs = '0;
  logic [2:0] cfg_mode = 3'd1;
  logic       cfg_write = 1'b0;
  logic       cfg_frag = 1'b0;
  logic [15:0] cfg_count = '0;
  logic       busy, done;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic [7:0] rx_data;
  logic       sclk;
  logic [1:0] cs_n;
  logic [3:0] io_out, io_oe, io_in;

  int checks = 0;
  int errors = 0;

  int rise_cnt = 0, cap_cnt = 0, rx_cnt = 0, tx_cnt = 0, done_cnt = 0, rd_step = 0;
  int cs_bad = 0, oe_bad = 0, hw_bad = 0;
  logic [3:0] cap [0:1023];
  logic [7:0] rx_got [0:63];

  int cur_mode = 1, cur_wr = 0, cur_count = 0, cur_t = 0, cur_spb = 8, cur_cs = 0;
  int rd_base = 0;
  int held = 0, sel = 0;

  always #2 clk = ~clk;

  qspi_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_cs(cfg_cs), .cfg_mode(cfg_mode),
    .cfg_write(cfg_write), .cfg_frag(cfg_frag), .cfg_count(cfg_count),
    .busy(busy), .done(done), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  function automatic logic [7:0] pat(int t, int k);
    return 8'(((t * 29) + (k * 83) + 60) ^ ((k * 16) + t));
  endfunction

  function automatic int spb_of(int m);
    if (m == 2) return 4;
    if (m == 3) return 2;
    return 8;
  endfunction

  // Read-side slave: presents the next bit group after each falling SCLK edge
  always_comb begin
    int s, k, j, w;
    logic [7:0] b;
    logic [7:0] g;
    io_in = 4'b0000;
    s = rd_step - rd_base;
    w = 8 / cur_spb;
    if (cur_wr == 0 && s < cur_count * cur_spb) begin
      k = s / cur_spb;
      j = s % cur_spb;
      b = pat(cur_t, k);
      g = 8'((b >> (8 - w * (j + 1))) & ((1 << w) - 1));
      if (w == 1)      io_in[1]   = g[0];
      else if (w == 2) io_in[1:0] = g[1:0];
      else             io_in[3:0] = g[3:0];
    end
  end

  always @(negedge sclk) rd_step <= rd_step + 1;

  always @(posedge sclk) begin
    rise_cnt <= rise_cnt + 1;
    cap[cap_cnt % 1024] <= io_out;
    cap_cnt <= cap_cnt + 1;
    if (cs_n !== ~(2'b01 << cur_cs)) cs_bad <= cs_bad + 1;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (done) done_cnt <= done_cnt + 1;
      if (tx_valid && tx_ready) tx_cnt <= tx_cnt + 1;
      if (rx_valid && rx_ready) begin
        rx_got[rx_cnt % 64] <= rx_data;
        rx_cnt <= rx_cnt + 1;
      end
      if (busy) begin
        logic [3:0] m;
        m = (cur_spb == 2) ? 4'b1111 : (cur_spb == 4) ? 4'b0011 : 4'b0001;
        if (cur_wr != 0) begin
          if (io_oe !== (m | 4'b1100)) oe_bad <= oe_bad + 1;
        end else begin
          if (io_oe !== ((cur_spb == 2) ? 4'b0000 : 4'b1100)) oe_bad <= oe_bad + 1;
        end
        if (cur_spb != 2 && io_out[3:2] !== 2'b11) hw_bad <= hw_bad + 1;
      end else begin
        if (io_oe[3:2] !== 2'b11 || io_out[3:2] !== 2'b11) hw_bad <= hw_bad + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int cs, input int mode, input int wr, input int frag,
                          input int count, input int t, input int stall, input int poke);
    int r0, c0, rx0, tx0, d0, csb0, oeb0, hwb0, cyc, spb, ecs, firstbad_a, firstbad_e;
    bit got, ok;
    spb = spb_of(mode);
    r0 = rise_cnt; c0 = cap_cnt; rx0 = rx_cnt; tx0 = tx_cnt; d0 = done_cnt;
    csb0 = cs_bad; oeb0 = oe_bad; hwb0 = hw_bad;
    @(negedge clk);
    rd_base = rd_step;
    if (count != 0) begin
      cur_mode = mode; cur_wr = wr; cur_count = count; cur_t = t; cur_spb = spb; cur_cs = cs;
    end
    cfg_cs = 1'(cs); cfg_mode = 3'(mode); cfg_write = 1'(wr); cfg_frag = 1'(frag);
    cfg_count = 16'(count);
    start = 1'b1;
    tx_valid = (wr != 0) && (count > 0);
    tx_data = pat(t, 0);
    rx_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; got = 0;
    while (!got && cyc < 3000) begin
      if (done) got = 1;
      else begin
        int k;
        k = tx_cnt - tx0;
        tx_valid = (wr != 0) && (k < count) && !(stall != 0 && (cyc % 5) < 2);
        tx_data = pat(t, k);
        rx_ready = !(stall != 0 && (cyc % 7) < 3);
        start = (poke != 0 && cyc == 8);
        if (start) begin cfg_count = 16'd1; cfg_mode = 3'd3; cfg_write = ~cfg_write; end
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    chk(got, "R8 done reached", int'(got), 1);
    if (count == 0) chk(cyc == 0, "R7 zero-count done on next cycle", cyc, 0);
    tx_valid = 1'b0; rx_ready = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    chk(done_cnt - d0 == 1, "R8 done pulse count", done_cnt - d0, 1);
    chk(busy == 1'b0, "R8 busy low after done", int'(busy), 0);
    chk(rise_cnt - r0 == count * spb, (count == 0) ? "R7 no SCLK on zero count" :
        "R1 R4 SCLK rising edges", rise_cnt - r0, count * spb);
    if (poke != 0) chk(rise_cnt - r0 == count * spb, "R8 start while busy ignored",
                       rise_cnt - r0, count * spb);
    if (wr != 0 && count > 0) begin
      ok = 1; firstbad_a = 0; firstbad_e = 0;
      for (int k = 0; k < count; k++) begin
        logic [7:0] b;
        b = '0;
        for (int j = 0; j < spb; j++) begin
          logic [3:0] l;
          l = cap[(c0 + k * spb + j) % 1024];
          if (spb == 8)      b = {b[6:0], l[0]};
          else if (spb == 4) b = {b[5:0], l[1:0]};
          else               b = {b[3:0], l[3:0]};
        end
        if (ok && b !== pat(t, k)) begin ok = 0; firstbad_a = int'(b); firstbad_e = int'(pat(t, k)); end
      end
      chk(ok, (stall != 0) ? "R2 R11 written bytes under stall" : "R2 written bytes",
          firstbad_a, firstbad_e);
      chk(tx_cnt - tx0 == count, "R11 tx bytes accepted", tx_cnt - tx0, count);
    end
    if (wr == 0 && count > 0) begin
      chk(rx_cnt - rx0 == count, "R12 rx bytes delivered", rx_cnt - rx0, count);
      ok = 1; firstbad_a = 0; firstbad_e = 0;
      for (int k = 0; k < count; k++)
        if (ok && rx_got[(rx0 + k) % 64] !== pat(t, k)) begin
          ok = 0; firstbad_a = int'(rx_got[(rx0 + k) % 64]); firstbad_e = int'(pat(t, k));
        end
      chk(ok, (stall != 0) ? "R3 R12 read bytes under stall" : "R3 read bytes",
          firstbad_a, firstbad_e);
    end
    chk(cs_bad == csb0, "R5 chip select at SCLK edges", cs_bad - csb0, 0);
    chk(oe_bad == oeb0, "R9 output enables", oe_bad - oeb0, 0);
    chk(hw_bad == hwb0, "R10 IO2/IO3 held high", hw_bad - hwb0, 0);
    if (count == 0) held = held & frag;
    else begin held = frag; sel = cs; end
    ecs = (held != 0) ? int'(~(2'b01 << sel)) & 3 : 3;
    chk(int'(cs_n) == ecs, "R6 chip select after done", int'(cs_n), ecs);
  endtask

  initial begin
    int modes [5] = '{0, 1, 2, 3, 5};
    int counts [5] = '{0, 1, 2, 3, 5};
    int t;
    repeat (3) @(negedge clk);
    chk(cs_n == 2'b11, "R5 reset chip selects", int'(cs_n), 3);
    chk(sclk == 1'b0, "R4 reset SCLK low", int'(sclk), 0);
    chk(done == 1'b0 && busy == 1'b0, "R8 reset idle", int'({done, busy}), 0);
    chk(io_oe == 4'b1100 && io_out[3:2] == 2'b11, "R10 reset IO2/IO3 high", int'(io_oe), 12);
    chk(rx_valid == 1'b0 && tx_ready == 1'b0, "R12 reset streams idle", int'({rx_valid, tx_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t = 0;
    foreach (modes[mi])
      for (int wr = 0; wr < 2; wr++)
        foreach (counts[ci])
          for (int fr = 0; fr < 2; fr++)
            for (int cs = 0; cs < 2; cs++) begin
              run_xfer(cs, modes[mi], wr, fr, counts[ci], t, t % 2, 0);
              t++;
            end
    run_xfer(0, 1, 1, 0, 3, t, 0, 1);
    t++;
    run_xfer(1, 2, 0, 0, 3, t, 1, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule